// File: doc/BRIEF.md
# Strobe-Gated Sequential FIR Filter

This block is a finite impulse response filter that runs on a fast system clock while its samples arrive at a much lower rate. A built-in rate divider counts system clocks and raises a one-cycle sample strobe once every `divVal` clocks. The divide value can be changed at run time. A sample is taken from `inData` only on a cycle where the strobe and the caller's `inValid` are both high. On each sample it takes, the tap delay line moves forward by one position. Each unit delay therefore lasts one sample period, not one clock.

The divider guarantees at least `MIN_DIV` clocks between samples. That gap lets one signed multiplier and one accumulator walk through the taps one per clock after each accepted sample. The full-precision sum is then rounded, saturated and presented on `outData` with a one-cycle `outValid`. The coefficients are fixed at build time and packed into a parameter. Tap k, where tap 0 holds the newest sample, takes its coefficient from bits `[k*COEF_W +: COEF_W]` of that parameter.

Top module: `strobe_fir`

## Requirements
- R1: After reset, `sampleStrobe` is high for exactly one cycle out of every P cycles, where P is the effective divide value.
- R2: A `divVal` below `MIN_DIV`, including 0, is treated as `MIN_DIV`.
- R3: A new `divVal` takes effect only at a counter wrap. The interval that follows each strobe equals the effective value of `divVal` present on that strobe cycle, whatever `divVal` does during the interval.
- R4: A sample is accepted only on a cycle with `sampleStrobe` and `inValid` both high. On every other cycle `inData` is ignored, the delay line keeps its contents, and no output is produced for it.
- R5: Each accepted sample shifts the delay line exactly once. The resulting output is the sum over k of coef[k]·x[n−k]. Data and coefficients are signed two's complement, and coefficient k sits at bits `[k*COEF_W +: COEF_W]` of `COEFS`.
- R6: The full-precision sum is rounded as (sum + 2^(SHIFT−1)) arithmetically shifted right by SHIFT, so that halves round upward.
- R7: A rounded value outside the signed `OUT_W` range is clamped to the nearest limit, +2^(OUT_W−1)−1 or −2^(OUT_W−1).
- R8: For each accepted sample, `outValid` is high for exactly one cycle: the cycle that begins NUM_TAPS+1 clock edges after the accepting edge. `outData` holds its value between pulses.
- R9: A synchronous reset clears the delay line, the accumulator, the divider counter, `outData` and `outValid`. After reset, no `outValid` appears until a sample has been accepted and fully processed.
- R10: With NUM_TAPS ≤ MIN_DIV, a new sample is never accepted while any tap other than the last is still pending in the multiply-accumulate sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divVal | input | CNT_W | Requested clocks per sample |
| inData | input | DATA_W | Signed input sample |
| inValid | input | 1 | Caller qualifier for the sample offered on a strobe cycle |
| sampleStrobe | output | 1 | One-cycle strobe from the rate divider |
| outData | output | OUT_W | Rounded and saturated filter output |
| outValid | output | 1 | One-cycle flag marking a new output |

## Verification
The hardest behaviour to reach from the ports is a change of `divVal` in the middle of an interval. The old value must keep governing until the wrap, so the stimulus moves `divVal` every few clocks between unrelated values, including values below the floor. Each interval is then compared with the value present on the preceding strobe. The bench also reaches exact rounding halves (an impulse of ±8 against a coefficient of 17) and both saturation limits (long runs of full-scale samples). It rejects every fifth strobe with `inValid` low while driving junk on `inData`, which checks that the delay line is untouched across the rejected sample.

// File: rtl/strobe_fir_pkg.sv
package strobe_fir_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic shift;  // take a new sample into the delay line
    logic mac;    // accumulate the product of the selected tap
    logic clr;    // first tap of a pass: replace the accumulator
    logic load;   // register the rounded result and flag it valid
  } fir_ctrl_t;
endpackage

// File: rtl/fir_rate_div.sv
module fir_rate_div #(
  parameter int CNT_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] divVal,
  output logic             strobe
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DIV);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curDiv;
  logic [CNT_W-1:0] safeDiv;

  assign safeDiv = (divVal < FLOOR) ? FLOOR : divVal;
  assign strobe  = (cnt == curDiv - 1'b1);

  // The divide value is sampled only at a wrap (or in reset).
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      curDiv <= safeDiv;
    end else if (strobe) begin
      cnt    <= '0;
      curDiv <= safeDiv;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R1: the strobe never lasts two cycles
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  // R2: the active divide never drops below the floor
  p_div_floor_r2: assert property (@(posedge clk) disable iff (rst)
    curDiv >= FLOOR);

  // R3: the active divide changes only across a wrap
  p_div_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(curDiv));
endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import strobe_fir_pkg::*;
#(
  parameter int NUM_TAPS = 4,
  localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             inValid,
  output fir_ctrl_t        ctrl,
  output logic [IDX_W-1:0] tapIdx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TAPS - 1);

  logic accept;
  logic busy;
  logic loadPend;
  logic lastTap;

  assign accept  = strobe & inValid;
  assign lastTap = (tapIdx == LAST);

  assign ctrl.shift = accept;
  assign ctrl.mac   = busy;
  assign ctrl.clr   = busy && (tapIdx == '0);
  assign ctrl.load  = loadPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tapIdx   <= '0;
      loadPend <= 1'b0;
    end else begin
      loadPend <= busy && lastTap;
      if (accept) begin
        busy   <= 1'b1;
        tapIdx <= '0;
      end else if (busy) begin
        if (lastTap) busy <= 1'b0;
        else         tapIdx <= tapIdx + 1'b1;
      end
    end
  end

  // R10: a new sample never lands while earlier taps are still pending
  p_budget_r10: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!busy || lastTap));
endmodule

// File: rtl/fir_dp.sv
module fir_dp
  import strobe_fir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 10,
  parameter int NUM_TAPS = 4,
  parameter int SHIFT    = 4,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = 32'h03FB1140,
  localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fir_ctrl_t                ctrl,
  input  logic [IDX_W-1:0]         tapIdx,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [OUT_W-1:0]  outData,
  output logic                     outValid
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + IDX_W + 1;
  localparam logic signed [ACC_W:0] HALF    = (ACC_W+1)'(1 << (SHIFT - 1));
  localparam logic signed [ACC_W:0] OUT_MAX = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] OUT_MIN = -OUT_MAX - 1;

  logic signed [DATA_W-1:0] line    [NUM_TAPS];
  logic signed [COEF_W-1:0] coefArr [NUM_TAPS];

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_coef
    assign coefArr[k] = COEFS[k*COEF_W +: COEF_W];
  end

  // Delay line: one step per accepted sample, tap 0 newest.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_TAPS; k++) line[k] <= '0;
    end else if (ctrl.shift) begin
      line[0] <= inData;
      for (int k = 1; k < NUM_TAPS; k++) line[k] <= line[k-1];
    end
  end

  logic signed [DATA_W-1:0] tapSel;
  logic signed [COEF_W-1:0] coefSel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  acc;

  assign tapSel  = line[tapIdx];
  assign coefSel = coefArr[tapIdx];
  assign prod    = PROD_W'(tapSel) * PROD_W'(coefSel);
  assign prodExt = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (ctrl.mac) acc <= ctrl.clr ? prodExt : acc + prodExt;
  end

  logic signed [ACC_W:0]   rnd;
  logic signed [ACC_W:0]   shifted;
  logic signed [OUT_W-1:0] satVal;

  always_comb begin
    rnd     = (ACC_W+1)'(acc) + HALF;
    shifted = rnd >>> SHIFT;
    if (shifted > OUT_MAX)      satVal = OUT_MAX[OUT_W-1:0];
    else if (shifted < OUT_MIN) satVal = OUT_MIN[OUT_W-1:0];
    else                        satVal = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) outData <= satVal;
    end
  end

  // R8: output valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8: output data holds between pulses
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(outData));

  // R5: the MAC only runs with the delay line frozen except at its final tap
  p_mac_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mac && ctrl.shift) |-> (tapIdx == IDX_W'(NUM_TAPS - 1)));
endmodule

// File: rtl/strobe_fir.sv
module strobe_fir
  import strobe_fir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 10,
  parameter int NUM_TAPS = 4,
  parameter int SHIFT    = 4,
  parameter int CNT_W    = 8,
  parameter int MIN_DIV  = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = 32'h03FB1140
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         divVal,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     inValid,
  output logic                     sampleStrobe,
  output logic signed [OUT_W-1:0]  outData,
  output logic                     outValid
);
  localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

  fir_ctrl_t        ctrl;
  logic [IDX_W-1:0] tapIdx;

  fir_rate_div #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst(rst), .divVal(divVal), .strobe(sampleStrobe)
  );

  fir_seq #(.NUM_TAPS(NUM_TAPS)) u_seq (
    .clk(clk), .rst(rst), .strobe(sampleStrobe), .inValid(inValid),
    .ctrl(ctrl), .tapIdx(tapIdx)
  );

  fir_dp #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .NUM_TAPS(NUM_TAPS), .SHIFT(SHIFT), .COEFS(COEFS)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .tapIdx(tapIdx), .inData(inData),
    .outData(outData), .outValid(outValid)
  );
endmodule

// File: tb/strobe_fir_bench.sv
`timescale 1ns/1ps
module strobe_fir_bench;
  localparam int DATA_W = 8, COEF_W = 8, OUT_W = 10, NUM_TAPS = 4;
  localparam int SHIFT = 4, CNT_W = 8, MIN_DIV = 8;
  localparam logic [NUM_TAPS*COEF_W-1:0] COEFS = 32'h03FB1140;

  logic clk = 1'b0;
  logic rst;
  logic [CNT_W-1:0] divVal;
  logic signed [DATA_W-1:0] inData;
  logic inValid;
  logic sampleStrobe;
  logic signed [OUT_W-1:0] outData;
  logic outValid;

  strobe_fir #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .NUM_TAPS(NUM_TAPS),
    .SHIFT(SHIFT), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV), .COEFS(COEFS)
  ) u_strobe_fir (
    .clk(clk), .rst(rst), .divVal(divVal), .inData(inData), .inValid(inValid),
    .sampleStrobe(sampleStrobe), .outData(outData), .outValid(outValid)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int strobeCount = 0, sampleCount = 0;
  int lastStrobe = -1, expPeriod = 0, pendCyc = 0;
  bit pendActive = 0, r3Phase = 0, lowDiv = 0;
  longint pendVal = 0;
  longint line [NUM_TAPS];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int effDiv(input int d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  function automatic longint coefOf(input int k);
    logic signed [COEF_W-1:0] c;
    c = COEFS[k*COEF_W +: COEF_W];
    return longint'(c);
  endfunction

  // R5 R6 R7: reference sum, rounding and clamp
  function automatic longint modelOut();
    longint acc, r, hi, lo;
    acc = 0;
    for (int k = 0; k < NUM_TAPS; k++) acc += coefOf(k) * line[k];
    r  = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
    hi = (longint'(1) <<< (OUT_W - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  function automatic logic signed [DATA_W-1:0] pattern(input int s, input logic [15:0] rnd);
    int ph;
    ph = s % 160;
    if (ph < 40) begin
      if (s % 5 != 0) return '0;
      case ((s / 5) % 4)
        0: return 8'sd1;
        1: return -8'sd1;
        2: return 8'sd8;
        default: return -8'sd8;
      endcase
    end
    if (ph < 70)  return 8'sd127;
    if (ph < 100) return -8'sd128;
    return rnd[7:0];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      for (int k = 0; k < NUM_TAPS; k++) line[k] = 0;
      pendActive = 0;
      lastStrobe = -1;
    end else begin
      // R8 R4 R9: outValid exactly when an accepted sample is due
      begin
        bit expV;
        expV = pendActive && (cyc == pendCyc);
        if (expV || outValid) begin
          check(outValid === expV, "R8 R4 R9 outValid", outValid, expV);
          if (expV) begin
            check(longint'(outData) == pendVal, "R5 R6 R7 outData", longint'(outData), pendVal);
            pendActive = 0;
          end
        end
      end
      if (sampleStrobe) begin
        if (lastStrobe >= 0)
          check(cyc - lastStrobe == expPeriod,
                r3Phase ? "R3 interval" : (lowDiv ? "R2 interval" : "R1 interval"),
                cyc - lastStrobe, expPeriod);
        lastStrobe = cyc;
        expPeriod  = effDiv(int'(divVal));
        strobeCount++;
        if (inValid) begin
          for (int k = NUM_TAPS - 1; k > 0; k--) line[k] = line[k-1];
          line[0]    = longint'(inData);
          pendVal    = modelOut();
          pendCyc    = cyc + NUM_TAPS + 2;
          pendActive = 1;
          sampleCount++;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    inValid = (strobeCount % 5) != 3;  // R4: every fifth strobe rejected
    inData  = sampleStrobe ? pattern(sampleCount, lfsr) : lfsr[15:8];
  endtask

  task automatic runStrobes(input int d, input int n);
    int target;
    divVal = CNT_W'(d);
    lowDiv = (d < MIN_DIV);
    target = strobeCount + n;
    while (strobeCount < target) step();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (4) step();
    @(negedge clk);
    check(outValid === 1'b0, "R9 reset outValid", outValid, 0);
    check(outData === '0, "R9 reset outData", longint'(outData), 0);
    check(sampleStrobe === 1'b0, "R9 reset strobe", sampleStrobe, 0);
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; divVal = 8'd8; inValid = 1'b0; inData = '0;
    doReset();
    runStrobes(8, 30);
    runStrobes(9, 20);
    runStrobes(12, 20);
    runStrobes(25, 10);
    runStrobes(3, 20);   // R2
    runStrobes(0, 10);   // R2
    // R3: move divVal mid-interval every few clocks
    r3Phase = 1;
    begin
      int target;
      target = strobeCount + 40;
      while (strobeCount < target) begin
        if (cyc % 3 == 0) divVal = CNT_W'(5 + (lfsr % 12));
        step();
      end
    end
    r3Phase = 0;
    runStrobes(8, 4);
    doReset();           // R9 mid-run
    runStrobes(8, 60);
    runStrobes(10, 30);
    repeat (NUM_TAPS + 4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule